// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the internal column address for each beat of one memory read or write burst. It holds a small mode register. The register sets the burst length, the beat ordering and a CAS latency value, and the latency value is passed on to the data path unchanged. A start pulse loads an 8-bit starting column. Each advance pulse then steps to the next beat. The block can end a burst early on a stop input, and it drops the old burst at once when a new start arrives.

Each burst takes its settings from the mode register in the cycle of its start. A later mode write therefore changes only the bursts that begin after it. There are three orderings: sequential wrap inside the aligned burst block, interleaved ordering (the low start bits are XORed with the beat number) and a full-page walk across the whole row.

Top module: `burst_colgen`

## Requirements
- R1: After reset, col_valid and last_beat are 0, cas_lat is 2, bl_illegal is 0, and the mode register holds burst-length code 001 (2 beats) with sequential order.
- R2: A mode write (mode_we=1) stores mode_wdata: bits 2:0 are the burst-length code, bit 3 is the order (0 sequential, 1 interleave), bits 6:4 are the CAS latency. cas_lat and bl_illegal show the new value from the next cycle on, and the register keeps its value while mode_we=0.
- R3: In the cycle after start=1, col_valid is 1 and col_addr equals start_col (beat 0).
- R4: In sequential order with burst length L (code 001=2, 010=4, 011=8), beat b has address (S & ~(L-1)) | ((S+b) & (L-1)).
- R5: In interleave order with burst length L, beat b has address S XOR (b & (L-1)).
- R6: Code 111 is full page: beat b has address (S+b) mod 256, the walk wraps past column 255, the order bit is ignored and last_beat stays 0 until a stop or a new start.
- R7: last_beat is 1 exactly on beat L-1. An advance on that beat clears col_valid in the next cycle.
- R8: While advance=0, a valid burst holds its address and stays valid.
- R9: burst_stop=1 during a valid burst clears col_valid in the next cycle.
- R10: start=1 during a burst (also together with burst_stop) restarts at the new start_col in the next cycle.
- R11: Burst-length codes 000, 100, 101 and 110 act as length 2, and bl_illegal is 1 while such a code is stored.
- R12: A burst keeps the length and order that were stored when it started. Mode writes during the burst do not change its addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 7 | Mode value: {cas[2:0], order, blcode[2:0]} |
| start | input | 1 | Begin a burst at start_col |
| start_col | input | 8 | Starting column |
| advance | input | 1 | Step to the next beat |
| burst_stop | input | 1 | End the current burst |
| col_addr | output | 8 | Current beat column address |
| col_valid | output | 1 | A beat is presented |
| last_beat | output | 1 | Current beat is the final one |
| cas_lat | output | 3 | Stored CAS latency |
| bl_illegal | output | 1 | Stored burst-length code is undefined |

## Verification
Two pairs of events can land in the same cycle, and both pairs are tested. The first pair is a stop and a new start. The bench raises burst_stop and start together partway through a burst, and it passes only if the next cycle shows beat 0 of the new burst. The second pair is a mode write and an active burst. The bench changes length and order partway through a burst. It then checks that the remaining beats still follow the old settings and that the next burst follows the new ones.

// File: rtl/burst_colgen_pkg.sv
// Package: shared mode-register layout and burst-length decode.
// Assumes the mode word is {cas[2:0], order, blcode[2:0]}.
package burst_colgen_pkg;

    localparam int MODE_W = 7;

    typedef enum logic [2:0] {
        BLC_2    = 3'b001,
        BLC_4    = 3'b010,
        BLC_8    = 3'b011,
        BLC_PAGE = 3'b111
    } bl_code_e;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_INTLV = 1'b1
    } order_e;

    typedef struct packed {
        logic [2:0] cas;
        order_e     order;
        logic [2:0] blc;
    } mode_t;

    // True when the code names a defined burst length.
    function automatic logic bl_known(input logic [2:0] c);
        return (c == BLC_2) || (c == BLC_4) || (c == BLC_8) || (c == BLC_PAGE);
    endfunction

    // Number of wrapping address bits for a fixed-length code (undefined -> 1).
    function automatic logic [1:0] bl_log2(input logic [2:0] c);
        case (c)
            BLC_4:   return 2'd2;
            BLC_8:   return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/bcg_mode_reg.sv
// Module: mode register. Holds burst length, order and CAS latency.
// Assumes writes come from a single strobe. The reset value selects 2 beats,
// sequential order, latency 2.
module bcg_mode_reg
    import burst_colgen_pkg::*;
#(
    parameter logic [2:0] CAS_RESET = 3'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    output mode_t             mode_q,
    output logic [2:0]        cas_lat,
    output logic              bl_illegal
);

    // Register the mode word on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '{cas: CAS_RESET, order: ORD_SEQ, blc: BLC_2};
        end else if (we) begin
            mode_q <= mode_t'(wdata);
        end
    end

    // Export latency and the undefined-length flag.
    always_comb begin
        cas_lat    = mode_q.cas;
        bl_illegal = !bl_known(mode_q.blc);
    end

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mode_q));

endmodule

// File: rtl/bcg_seq.sv
// Module: burst sequencer. Latches the start column and the burst settings,
// counts beats, and handles stop, restart and end of burst.
// Assumes COL_W >= 3, so that an 8-beat block fits in the column width.
module bcg_seq
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode_q,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             advance,
    input  logic             stop,
    output logic             valid,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] mask,
    output logic             intlv,
    output logic             last
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic             page;
    logic             page_d;
    logic [COL_W-1:0] mask_d;

    // Decode the wrap mask for the burst about to start.
    always_comb begin
        page_d = (mode_q.blc == BLC_PAGE);
        if (page_d) mask_d = '1;
        else        mask_d = (ONE << bl_log2(mode_q.blc)) - ONE;
    end

    // Flag the final beat of a fixed-length burst.
    always_comb begin
        last = valid && !page && (beat == mask);
    end

    // Burst state: start wins over stop, and stop wins over advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            base  <= '0;
            beat  <= '0;
            mask  <= '0;
            intlv <= 1'b0;
            page  <= 1'b0;
        end else if (start) begin
            valid <= 1'b1;
            base  <= start_col;
            beat  <= '0;
            mask  <= mask_d;
            intlv <= (mode_q.order == ORD_INTLV) && !page_d;
            page  <= page_d;
        end else if (valid && stop) begin
            valid <= 1'b0;
        end else if (valid && advance) begin
            if (last) valid <= 1'b0;
            else      beat  <= beat + ONE;
        end
    end

    // R7
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> valid);

    // R9
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && stop && !start |=> !valid);

    // R8
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !advance && !stop && !start |=> valid && $stable(beat));

    // R6
    page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && page |-> !last);

endmodule

// File: rtl/bcg_addr_map.sv
// Module: address mapper. Builds the beat address from the base column and
// the beat count. The bits under the mask follow the chosen order, and the
// bits above the mask stay as in the base.
// Assumes mask is a contiguous run of low ones.
module bcg_addr_map #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             intlv,
    output logic [COL_W-1:0] addr
);

    logic [COL_W-1:0] sum;

    // Sequential candidate: base plus beat, taken modulo the column width.
    always_comb begin
        sum = base + beat;
    end

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        // Select the wrapped bit, the XORed bit or the fixed base bit.
        always_comb begin
            if (!mask[i])   addr[i] = base[i];
            else if (intlv) addr[i] = base[i] ^ beat[i];
            else            addr[i] = sum[i];
        end
    end

endmodule

// File: rtl/burst_colgen.sv
// Module: burst column address generator (top). Connects the mode register,
// the sequencer and the address mapper.
// Assumes single-cycle start, advance and stop pulses in the clk domain.
module burst_colgen
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              advance,
    input  logic              burst_stop,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_valid,
    output logic              last_beat,
    output logic [2:0]        cas_lat,
    output logic              bl_illegal
);

    mode_t            mode_q;
    logic [COL_W-1:0] base, beat, mask;
    logic             intlv;

    bcg_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n), .we(mode_we), .wdata(mode_wdata),
        .mode_q(mode_q), .cas_lat(cas_lat), .bl_illegal(bl_illegal)
    );

    bcg_seq #(.COL_W(COL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .start(start),
        .start_col(start_col), .advance(advance), .stop(burst_stop),
        .valid(col_valid), .base(base), .beat(beat), .mask(mask),
        .intlv(intlv), .last(last_beat)
    );

    bcg_addr_map #(.COL_W(COL_W)) u_map (
        .base(base), .beat(beat), .mask(mask), .intlv(intlv), .addr(col_addr)
    );

    // R3
    start_beat0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> col_valid && (col_addr == $past(start_col)));

    // R10
    restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && burst_stop |=> col_valid);

endmodule

// File: tb/burst_colgen_test.sv
module burst_colgen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [6:0] mode_wdata = '0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic       advance = 1'b0;
    logic       burst_stop = 1'b0;
    logic [7:0] col_addr;
    logic       col_valid, last_beat, bl_illegal;
    logic [2:0] cas_lat;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    burst_colgen uut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .start(start), .start_col(start_col), .advance(advance),
        .burst_stop(burst_stop), .col_addr(col_addr), .col_valid(col_valid),
        .last_beat(last_beat), .cas_lat(cas_lat), .bl_illegal(bl_illegal)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_mode(input logic [2:0] cl, input logic ord, input logic [2:0] blc);
        mode_we = 1'b1; mode_wdata = {cl, ord, blc};
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    function automatic int exp_addr(input int s, input int b, input int len, input logic ord);
        int m = len - 1;
        if (ord) return s ^ (b & m);
        return (s & ~m & 255) | ((s + b) & m);
    endfunction

    // Start a burst, advance through every beat, check each one and the end.
    task automatic run_burst(input string req, input int s, input int len, input logic ord);
        start = 1'b1; start_col = 8'(s);
        @(negedge clk);
        start = 1'b0; advance = 1'b1;
        for (int b = 0; b < len; b++) begin
            check({req, " valid"}, int'(col_valid), 1);
            check({req, " addr"}, int'(col_addr), exp_addr(s, b, len, ord));
            check("R7 last", int'(last_beat), (b == len - 1) ? 1 : 0);
            @(negedge clk);
        end
        check("R7 end", int'(col_valid), 0);
        advance = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", int'(col_valid), 0);
        check("R1 last", int'(last_beat), 0);
        check("R1 cas", int'(cas_lat), 2);
        check("R1 illegal", int'(bl_illegal), 0);
        run_burst("R1 default", 6, 2, 1'b0);

        // R2 register write, R4 and R5 sweeps
        write_mode(3'd5, 1'b0, 3'b010);
        check("R2 cas", int'(cas_lat), 5);
        check("R2 illegal", int'(bl_illegal), 0);
        @(negedge clk);
        check("R2 hold", int'(cas_lat), 5);
        for (int lc = 1; lc <= 3; lc++) begin
            for (int o = 0; o < 2; o++) begin
                write_mode(3'd3, o[0], lc[2:0]);
                for (int s = 0; s < 256; s++)
                    run_burst(o ? "R5" : "R4", s, 1 << lc, o[0]);
            end
        end

        // R11 undefined codes behave as length 2
        for (int k = 0; k < 4; k++) begin
            logic [2:0] c = (k == 0) ? 3'b000 : 3'(3 + k);
            write_mode(3'd2, 1'b0, c);
            check("R11 flag", int'(bl_illegal), 1);
            run_burst("R11", 8'h37 + k, 2, 1'b0);
        end

        // R6 full page, order bit ignored, wrap at the row end
        write_mode(3'd2, 1'b1, 3'b111);
        check("R6 flag", int'(bl_illegal), 0);
        start = 1'b1; start_col = 8'd250;
        @(negedge clk);
        start = 1'b0; advance = 1'b1;
        for (int b = 0; b < 300; b++) begin
            check("R6 valid", int'(col_valid), 1);
            check("R6 addr", int'(col_addr), (250 + b) % 256);
            check("R6 last", int'(last_beat), 0);
            @(negedge clk);
        end
        advance = 1'b0; burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        check("R9 page stop", int'(col_valid), 0);

        // R8 hold and R9 stop in a fixed burst
        write_mode(3'd2, 1'b0, 3'b011);
        start = 1'b1; start_col = 8'd21;
        @(negedge clk);
        start = 1'b0; advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 valid", int'(col_valid), 1);
        check("R8 addr", int'(col_addr), 22);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        check("R9 stop", int'(col_valid), 0);
        check("R9 last", int'(last_beat), 0);

        // R10 start together with stop during a burst
        start = 1'b1; start_col = 8'd10;
        @(negedge clk);
        start = 1'b0; advance = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 mid", int'(col_addr), exp_addr(10, 3, 8, 1'b0));
        start = 1'b1; burst_stop = 1'b1; start_col = 8'd100;
        @(negedge clk);
        start = 1'b0; burst_stop = 1'b0;
        for (int b = 0; b < 8; b++) begin
            check("R10 valid", int'(col_valid), 1);
            check("R10 addr", int'(col_addr), exp_addr(100, b, 8, 1'b0));
            @(negedge clk);
        end
        check("R10 end", int'(col_valid), 0);
        advance = 1'b0;

        // R12 mode write mid-burst does not change the running burst
        start = 1'b1; start_col = 8'd45;
        @(negedge clk);
        start = 1'b0; advance = 1'b1;
        for (int b = 0; b < 8; b++) begin
            mode_we = (b == 2); mode_wdata = {3'd4, 1'b1, 3'b010};
            check("R12 valid", int'(col_valid), 1);
            check("R12 addr", int'(col_addr), exp_addr(45, b, 8, 1'b0));
            @(negedge clk);
        end
        mode_we = 1'b0;
        check("R12 end", int'(col_valid), 0);
        advance = 1'b0;
        check("R12 cas", int'(cas_lat), 4);
        run_burst("R12 new", 45, 4, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule